// File: doc/BRIEF.md
# Shift-Gain PI Current Regulator

This block closes a digital current loop around a buck power stage. Each time the converter front end presents a new 10-bit current sample, the block takes the difference between a requested current and the measured current. It forms a proportional term and an integral increment from that error using arithmetic right shifts only, with no multiplier or divider. It then updates a limited integrator and produces a duty command confined to the PWM period. A free-running PWM counter turns the command into a single switching output. One count of current corresponds to roughly 9.8 mA, so the usable request window of 3 A to 8 A becomes a fixed band of sample counts.

The gains are deliberately low, which keeps the response overdamped. When the load is disconnected for a moment during switching, the output stays bounded rather than racing to full duty. A new duty command never changes a PWM period that is already in progress. The command is loaded only when the counter wraps.

Top module: `pi_current_reg`

## Requirements
- R1: After a synchronous active-high reset, `duty_cmd` is 0 and `pwm_out` stays low.
- R2: The requested current is limited to the band SP_MIN..SP_MAX (default 306..816 counts) before the error is formed. Requests outside the band behave like the nearest limit.
- R3: The error is the limited request minus `meas_data`, taken as a signed value. The proportional term is that error arithmetically shifted right by KP_SHIFT (default 1, a gain of one half, rounding toward minus infinity).
- R4: On each accepted sample, the integral increment is the error arithmetically shifted right by KI_SHIFT (default 3).
- R5: The integrator is held inside 0..PERIOD and saturates there instead of wrapping.
- R6: The duty command is the proportional term plus the updated integrator, clamped to 0..PERIOD.
- R7: When the clamp in R6 is active and the increment pushes further in the same direction, the integrator keeps its previous value. The duty is then formed from that previous value.
- R8: `duty_cmd` changes only in the clock after a cycle with `meas_valid` high. With `meas_valid` low, changes on `meas_data` or `req_current` have no effect.
- R9: The PWM counter runs from 0 to PERIOD-1 and wraps. The applied duty is reloaded from `duty_cmd` only at the wrap. During a period, `pwm_out` is high for exactly the applied duty number of cycles.
- R10: A duty of PERIOD holds `pwm_out` high for the whole period, and a duty of 0 holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | One-cycle strobe marking a fresh current sample |
| meas_data | input | 10 | Measured current, unsigned counts |
| req_current | input | 10 | Requested current, unsigned counts |
| duty_cmd | output | $clog2(PERIOD+1) | Latest computed duty, in PWM clock cycles |
| pwm_out | output | 1 | Switching output to the power stage |

## Verification
Several properties are checked on every cycle: the integrator and duty stay inside 0..PERIOD, the duty holds while no sample arrives, and the counter stays in range. The applied duty moves only at the counter wrap, and the output is fully on or fully off at the two duty extremes. Whether the shifted gains, the request band and the anti-windup hold give the right numbers can only be seen from the bench's scenarios. Those scenarios compare each new duty against a reference computed from the requirements, and they count the high cycles in whole PWM periods.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;

    // Common signed working width for the control arithmetic.
    localparam int CW = 16;
    typedef logic signed [CW-1:0] cw_t;

    // Terms handed from the error stage to the control law.
    typedef struct packed {
        cw_t prop;   // proportional contribution
        cw_t incr;   // integral increment for this sample
    } pi_terms_t;

    function automatic cw_t sat(cw_t v, cw_t lo, cw_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/pi_err_stage.sv
module pi_err_stage
    import pi_reg_pkg::*;
#(
    parameter int ADC_W    = 10,
    parameter int SP_MIN   = 306,
    parameter int SP_MAX   = 816,
    parameter int KP_SHIFT = 1,
    parameter int KI_SHIFT = 3
) (
    input  logic [ADC_W-1:0] meas,
    input  logic [ADC_W-1:0] req,
    output pi_terms_t        terms
);
    localparam int PADW = CW - ADC_W;

    cw_t req_s, req_lim, meas_s, err;

    always_comb begin
        req_s   = $signed({{PADW{1'b0}}, req});
        meas_s  = $signed({{PADW{1'b0}}, meas});
        // R2: request band limiter
        req_lim = sat(req_s, cw_t'(SP_MIN), cw_t'(SP_MAX));
        // R3: difference stage
        err     = req_lim - meas_s;
        terms.prop = err >>> KP_SHIFT;
        // R4: integral increment
        terms.incr = err >>> KI_SHIFT;
    end

endmodule

// File: rtl/pi_law.sv
module pi_law
    import pi_reg_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  pi_terms_t       terms,
    output logic [DW-1:0]   duty_q
);
    localparam cw_t LIM = cw_t'(PERIOD);

    cw_t           integ_q, integ_d, cand, u_try, u_fin;
    logic          wind;
    logic [DW-1:0] duty_d;

    always_comb begin
        // R5: integrator limiter
        cand  = sat(integ_q + terms.incr, cw_t'(0), LIM);
        u_try = terms.prop + cand;
        // R7: hold integrator when output saturates in the push direction
        wind  = ((u_try > LIM) && (terms.incr > 0)) ||
                ((u_try < 0)   && (terms.incr < 0));
        integ_d = wind ? integ_q : cand;
        u_fin   = terms.prop + integ_d;
        // R6: output limiter
        duty_d  = DW'(sat(u_fin, cw_t'(0), LIM));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            duty_q  <= '0;
        end else if (valid) begin
            integ_q <= integ_d;
            duty_q  <= duty_d;
        end
    end

    p_integ_range_r5: assert property (@(posedge clk) disable iff (rst)
        (integ_q >= 0) && (integ_q <= LIM));

    p_duty_range_r6: assert property (@(posedge clk) disable iff (rst)
        int'(duty_q) <= PERIOD);

    p_hold_no_sample_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(duty_q) && $stable(integ_q)));

    p_integ_direction_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && (terms.incr > 0)) |=> (integ_q >= $past(integ_q)));

endmodule

// File: rtl/pi_pwm.sv
module pi_pwm #(
    parameter int PERIOD = 200,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] duty_in,
    output logic          pwm
);
    localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);
    localparam logic [DW-1:0] FULL = DW'(PERIOD);

    logic [DW-1:0] cnt_q, live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            live_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            live_q <= duty_in;   // R9: reload only at the wrap
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign pwm = (cnt_q < live_q);

    p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_reload_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(live_q));

    p_full_on_r10: assert property (@(posedge clk) disable iff (rst)
        (live_q == FULL) |-> pwm);

    p_full_off_r10: assert property (@(posedge clk) disable iff (rst)
        (live_q == '0) |-> !pwm);

endmodule

// File: rtl/pi_current_reg.sv
module pi_current_reg
    import pi_reg_pkg::*;
#(
    parameter int ADC_W    = 10,
    parameter int PERIOD   = 200,
    parameter int SP_MIN   = 306,
    parameter int SP_MAX   = 816,
    parameter int KP_SHIFT = 1,
    parameter int KI_SHIFT = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          meas_valid,
    input  logic [ADC_W-1:0]              meas_data,
    input  logic [ADC_W-1:0]              req_current,
    output logic [$clog2(PERIOD+1)-1:0]   duty_cmd,
    output logic                          pwm_out
);
    localparam int DW = $clog2(PERIOD + 1);

    pi_terms_t terms;

    pi_err_stage #(
        .ADC_W(ADC_W), .SP_MIN(SP_MIN), .SP_MAX(SP_MAX),
        .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT)
    ) u_err (
        .meas (meas_data),
        .req  (req_current),
        .terms(terms)
    );

    pi_law #(.PERIOD(PERIOD), .DW(DW)) u_law (
        .clk   (clk),
        .rst   (rst),
        .valid (meas_valid),
        .terms (terms),
        .duty_q(duty_cmd)
    );

    pi_pwm #(.PERIOD(PERIOD), .DW(DW)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .duty_in(duty_cmd),
        .pwm    (pwm_out)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (duty_cmd == '0));

endmodule

// File: tb/pi_current_reg_test.sv
module pi_current_reg_test;
    localparam int P   = 200;
    localparam int DW  = $clog2(P + 1);
    localparam int SPL = 306;
    localparam int SPH = 816;
    localparam int KP  = 1;
    localparam int KI  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          meas_valid = 1'b0;
    logic [9:0]    meas_data = '0;
    logic [9:0]    req_current = '0;
    logic [DW-1:0] duty_cmd;
    logic          pwm_out;

    int checks = 0;
    int errors = 0;
    int integ_m = 0;
    int duty_m  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pi_current_reg #(.PERIOD(P)) uut (
        .clk(clk), .rst(rst), .meas_valid(meas_valid),
        .meas_data(meas_data), .req_current(req_current),
        .duty_cmd(duty_cmd), .pwm_out(pwm_out)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Reference model built from R2..R7
    task automatic model_step(int meas, int req);
        int e, p, inc, cand, u;
        e    = clampi(req, SPL, SPH) - meas;
        p    = e >>> KP;
        inc  = e >>> KI;
        cand = clampi(integ_m + inc, 0, P);
        u    = p + cand;
        if ((u > P && inc > 0) || (u < 0 && inc < 0)) cand = integ_m;
        integ_m = cand;
        duty_m  = clampi(p + integ_m, 0, P);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample(int meas, int req, string tag);
        @(negedge clk);
        meas_data   = 10'(meas);
        req_current = 10'(req);
        meas_valid  = 1'b1;
        @(negedge clk);
        meas_valid  = 1'b0;
        model_step(meas, req);
        check(tag, int'(duty_cmd), duty_m);
    endtask

    task automatic measure_pwm(string tag);
        int hi;
        hi = 0;
        repeat (2 * P) @(negedge clk);
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check(tag, hi, duty_m);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 duty after reset", int'(duty_cmd), 0);
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < P; k++) begin
                @(negedge clk);
                if (pwm_out) hi++;
            end
            check("R1 pwm low after reset", hi, 0);
        end

        // R3/R4 small positive error: req 320, meas 300 -> e 20, p 10, inc 2
        sample(300, 320, "R3 small error");
        check("R3 literal duty", int'(duty_cmd), 12);
        measure_pwm("R9 pwm high count");

        // R2: request above band behaves like 816
        sample(800, 1000, "R2 upper band");
        // R2: request below band behaves like 306
        sample(310, 5, "R2 lower band");

        // R8: inputs change without strobe -> no effect
        begin
            int held;
            held = int'(duty_cmd);
            @(negedge clk);
            meas_data = 10'd0; req_current = 10'd700;
            repeat (20) @(negedge clk);
            check("R8 ignored without valid", int'(duty_cmd), held);
        end

        // R7/R6/R10: large positive error drives to full
        for (int k = 0; k < 6; k++) sample(0, 816, "R7 windup up");
        check("R6 upper clamp", int'(duty_cmd), P);
        measure_pwm("R10 full on");

        // R7: recovery after windup with negative error
        sample(400, 400, "R7 zero error after sat");
        for (int k = 0; k < 8; k++) sample(1000, 306, "R5 integ low limit");
        check("R6 lower clamp", int'(duty_cmd), 0);
        measure_pwm("R10 full off");

        // R3 negative odd error rounding: req 306, meas 309 -> e -3
        sample(309, 306, "R3 negative rounding");

        // Random mix
        for (int k = 0; k < 120; k++) begin
            int m, s;
            m = int'($urandom_range(0, 1023));
            s = int'($urandom_range(0, 1023));
            if (k % 3 == 0) m = clampi(s + int'($urandom_range(0, 60)) - 30, 0, 1023);
            sample(m, s, "R6 random step");
            repeat (int'($urandom_range(0, 5))) @(negedge clk);
        end
        measure_pwm("R9 pwm after random");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule